// File: doc/BRIEF.md
# Folded-Array Synchronous Static Memory

This block is a 256-word by 16-bit synchronous static memory. Behind the interface it keeps a folded physical organisation: the bits sit in 64 rows of 64 bits, each row holding four 16-bit words side by side. The address splits into a row index, which a two-stage predecoded decoder turns into 64 one-hot wordlines, and a column index, which picks one of the four words inside the selected row. Total capacity is 4096 bits.

A user asserts chip select with an address and write enable on a rising clock edge. The wordline for that row is raised for exactly the next clock cycle and then drops again. At the end of that pulse cycle the array is written, or the read register is loaded. The data-out bus carries the read register only while both chip select and output enable are high. At all other times it is left undriven.

Top module: `sram_folded`

## Requirements
- R1: The row index is addr[7:2] and the column index is addr[1:0]. Every one of the 256 addresses stores its own 16-bit word and returns it on a later read.
- R2: A write replaces only the addressed 16-bit slice of its row. The other three words of that row keep their values.
- R3: In the cycle after a rising edge at which cs is high, exactly one wordline is high, namely wordline[addr[7:2]] with addr as sampled at that edge.
- R4: A wordline stays high for one cycle only. If cs was low at the edge that ends the pulse, all wordlines are low in the following cycle.
- R5: While cs is low at a rising edge, nothing is written, the read register keeps its value, and no wordline rises in the following cycle. This holds whatever we, addr and din carry.
- R6: we high at the sampling edge selects a write and we low selects a read. A write never changes the read register.
- R7: A read sampled at edge k loads its word into the read register at edge k+1. The register holds that word until the next read loads it, including through idle cycles and writes.
- R8: data_out drives the read register when cs and oe are both high. In every other case data_out is high-impedance. This follows cs and oe without a clock.
- R9: While rst_n is low, and right after it is released, all wordlines are low and the read register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of control state |
| cs | input | 1 | Chip select. High requests an access at the edge |
| we | input | 1 | High means write, low means read |
| oe | input | 1 | Enables the data-out drivers together with cs |
| addr | input | 8 | Word address: row in [7:2], column in [1:0] |
| din | input | 16 | Write data |
| data_out | output | 16 | Read data, or high-impedance |
| wordline | output | 64 | Pulsed one-hot row selects |

## Verification
On every cycle, the assertions check the following:
- the wordlines are one-hot after each selected edge, and one-hot for the sampled row;
- the wordlines stay silent after an unselected edge;
- the array contents are frozen whenever no wordline is high;
- the read register does not move on write or idle cycles.

Only the bench scenarios can show whether the right data comes back. These scenarios cover a full write and read-back sweep of all 256 addresses, and the preservation of sibling words in a row after a partial write. They also cover that writes with chip select low are discarded, and that a read result is held across later writes. The high-impedance behaviour of data_out under each cs/oe combination is also observed only by the bench, through pull-ups on the bus.

// File: rtl/sram_fold_pkg.sv
package sram_fold_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 16;
    localparam int COL_W    = 2;
    localparam int PREDEC_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } mem_op_e;
endpackage

// File: rtl/sram_row_decoder.sv
module sram_row_decoder #(
    parameter int ROW_BITS = 6,
    parameter int GRP_W    = 2,
    localparam int ROWS    = 1 << ROW_BITS,
    localparam int NGRP    = ROW_BITS / GRP_W,
    localparam int GRP_N   = 1 << GRP_W
) (
    input  logic                en,
    input  logic [ROW_BITS-1:0] row_addr,
    output logic [ROWS-1:0]     wl
);
    // stage one: each group of GRP_W address bits becomes a one-hot predecode
    logic [NGRP-1:0][GRP_N-1:0] pre;

    for (genvar g = 0; g < NGRP; g++) begin : g_pre
        always_comb begin
            for (int k = 0; k < GRP_N; k++) begin
                pre[g][k] = en && (row_addr[g*GRP_W +: GRP_W] == GRP_W'(k));
            end
        end
    end

    // stage two: one AND gate per row, one input from every predecoder
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_comb begin
            logic acc;
            acc = 1'b1;
            for (int g = 0; g < NGRP; g++) begin
                acc = acc & pre[g][GRP_W'((r >> (g*GRP_W)) & (GRP_N-1))];
            end
            wl[r] = acc;
        end
    end

    // R3: an enabled decode selects exactly one row, a disabled one none
    always_comb begin
        if (en) p_dec_onehot_r3 : assert ($onehot(wl));
        else    p_dec_silent_r5 : assert (wl == '0);
    end
endmodule

// File: rtl/sram_col_select.sv
module sram_col_select #(
    parameter int DATA_W = 16,
    parameter int COL_W  = 2,
    localparam int COLS  = 1 << COL_W,
    localparam int ROW_W = DATA_W * COLS
) (
    input  logic [ROW_W-1:0]  row_in,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rword,
    output logic [ROW_W-1:0]  row_wr
);
    // read side picks one slice; write side merges one slice into the row
    always_comb begin
        rword  = '0;
        row_wr = row_in;
        for (int c = 0; c < COLS; c++) begin
            if (col == COL_W'(c)) begin
                rword                      = row_in[c*DATA_W +: DATA_W];
                row_wr[c*DATA_W +: DATA_W] = wdata;
            end
        end
    end
endmodule

// File: rtl/sram_cell_array.sv
module sram_cell_array #(
    parameter int ROWS  = 64,
    parameter int ROW_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROWS-1:0]  wl,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    output logic [ROW_W-1:0] rd_row
);
    logic [ROWS-1:0][ROW_W-1:0] mem_d, mem_q;

    // shared bitline: every row gated by its own wordline, then ORed
    always_comb begin
        rd_row = '0;
        for (int r = 0; r < ROWS; r++) begin
            rd_row = rd_row | (mem_q[r] & {ROW_W{wl[r]}});
        end
    end

    always_comb begin
        mem_d = mem_q;
        for (int r = 0; r < ROWS; r++) begin
            if (wl[r] && wr_en) mem_d[r] = wr_row;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    // R5: cell contents cannot change without a wordline pulse
    p_no_wl_hold_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (wl == '0) |=> $stable(mem_q));
endmodule

// File: rtl/sram_folded.sv
module sram_folded #(
    parameter int ADDR_W   = sram_fold_pkg::ADDR_W,
    parameter int DATA_W   = sram_fold_pkg::DATA_W,
    parameter int COL_W    = sram_fold_pkg::COL_W,
    parameter int PREDEC_W = sram_fold_pkg::PREDEC_W,
    localparam int ROW_BITS = ADDR_W - COL_W,
    localparam int ROWS     = 1 << ROW_BITS,
    localparam int ROW_W    = DATA_W << COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic              oe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output wire  [DATA_W-1:0] data_out,
    output logic [ROWS-1:0]   wordline
);
    import sram_fold_pkg::*;

    typedef struct packed {
        logic [ROWS-1:0]   wl;
        mem_op_e           op;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] din;
        logic [DATA_W-1:0] rd;
    } state_t;

    state_t s_d, s_q;

    logic [ROWS-1:0]   dec_wl;
    logic [ROW_W-1:0]  rd_row;
    logic [ROW_W-1:0]  wr_row;
    logic [DATA_W-1:0] rd_word;

    sram_row_decoder #(
        .ROW_BITS (ROW_BITS),
        .GRP_W    (PREDEC_W)
    ) u_dec (
        .en       (cs),
        .row_addr (addr[ADDR_W-1:COL_W]),
        .wl       (dec_wl)
    );

    sram_col_select #(
        .DATA_W (DATA_W),
        .COL_W  (COL_W)
    ) u_col (
        .row_in (rd_row),
        .col    (s_q.col),
        .wdata  (s_q.din),
        .rword  (rd_word),
        .row_wr (wr_row)
    );

    sram_cell_array #(
        .ROWS  (ROWS),
        .ROW_W (ROW_W)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .wl     (s_q.wl),
        .wr_en  (s_q.op == OP_WRITE),
        .wr_row (wr_row),
        .rd_row (rd_row)
    );

    always_comb begin
        s_d     = s_q;
        s_d.wl  = dec_wl;
        s_d.op  = !cs ? OP_IDLE : (we ? OP_WRITE : OP_READ);
        s_d.col = addr[COL_W-1:0];
        s_d.din = din;
        if (s_q.op == OP_READ) s_d.rd = rd_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wordline = s_q.wl;
    assign data_out = (cs && oe) ? s_q.rd : {DATA_W{1'bz}};

    // R3: a selected edge raises exactly the sampled row's wordline
    p_access_fires_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        cs |=> ($countones(wordline) == 1));
    p_wl_row_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        cs |=> wordline[$past(addr[ADDR_W-1:COL_W])]);
    // R4: a pulse not renewed by cs collapses after one cycle
    p_pulse_one_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        ((wordline != '0) && !cs) |=> (wordline == '0));
    // R5: unselected edges leave the array lines quiet and the read register alone
    p_idle_quiet_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (wordline == '0));
    p_idle_keeps_rd_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.op == OP_IDLE) |=> $stable(s_q.rd));
    // R6: a write cycle never disturbs the read register
    p_write_keeps_rd_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.op == OP_WRITE) |=> $stable(s_q.rd));
endmodule

// File: tb/sram_folded_test.sv
module sram_folded_test;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs = 1'b0, we = 1'b0, oe = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    wire  [DW-1:0] dq;
    logic [NW-1:0] wordline;

    // pull-ups make a released bus visible as all ones
    for (genvar i = 0; i < DW; i++) begin : g_pu
        pullup (dq[i]);
    end

    sram_folded uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs       (cs),
        .we       (we),
        .oe       (oe),
        .addr     (addr),
        .din      (din),
        .data_out (dq),
        .wordline (wordline)
    );

    always #10 clk = ~clk;

    int            n_cmp = 0;
    int            n_bad = 0;
    bit            done = 1'b0;
    logic [DW-1:0] model [256];
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];
    event          chk_ev;

    // scoreboard monitor: compares the bus against the oldest expectation
    initial begin
        forever begin
            logic [DW-1:0] e;
            string t;
            @(chk_ev);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (dq !== e) begin
                n_bad++;
                $display("FAIL %s data_out got %h expected %h", t, dq, e);
            end
        end
    end

    task automatic expect_bus(string t, logic [DW-1:0] e);
        exp_q.push_back(e);
        tag_q.push_back(t);
        -> chk_ev;
        #1;
    endtask

    task automatic check_wl(string t, logic [NW-1:0] e);
        n_cmp++;
        if (wordline !== e) begin
            n_bad++;
            $display("FAIL %s wordline got %h expected %h", t, wordline, e);
        end
    endtask

    function automatic logic [DW-1:0] pat(int a);
        return DW'(a * 16'h0101) ^ 16'h5A3C;
    endfunction

    task automatic wr(int a, logic [DW-1:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = AW'(a); din = d;
        model[a] = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    // leaves cs high and oe high on return
    task automatic rd(int a, string t);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; oe = 1'b1; addr = AW'(a);
        @(negedge clk);
        check_wl("R3", NW'(1) << (a >> 2));
        @(negedge clk);
        expect_bus(t, model[a]);
    endtask

    task automatic idle_check();
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
        @(negedge clk);
        check_wl("R4", '0);
        expect_bus("R8", 16'hFFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_wl("R9", '0);
        expect_bus("R8", 16'hFFFF);
        rst_n = 1'b1;
        cs = 1'b1; oe = 1'b1; we = 1'b0; addr = '0;
        #1;
        expect_bus("R9", 16'h0000);
        @(negedge clk);
        cs = 1'b0;

        // R1: full sweep write then read back
        for (int a = 0; a < 256; a++) wr(a, pat(a));
        for (int a = 0; a < 256; a++) rd(a, "R1");
        idle_check();

        // R2: one slice of row 10 rewritten, siblings intact
        wr(41, 16'hBEEF);
        rd(40, "R2");
        rd(41, "R2");
        rd(42, "R2");
        rd(43, "R2");

        // R5: deselected write attempt leaves memory and wordlines quiet
        @(negedge clk);
        cs = 1'b0; we = 1'b1; addr = 8'd7; din = 16'h1234;
        @(negedge clk);
        check_wl("R5", '0);
        @(negedge clk);
        we = 1'b0;
        rd(7, "R5");

        // R6: a write after a read leaves the read register alone
        rd(100, "R6");
        we = 1'b1; din = 16'hDEAD; addr = 8'd100;
        @(negedge clk);
        @(negedge clk);
        expect_bus("R6", model[100]);
        model[100] = 16'hDEAD;
        cs = 1'b0; we = 1'b0;
        rd(100, "R6");

        // R7: result held through idle cycles and a later write elsewhere
        rd(200, "R7");
        idle_check();
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = 8'd5; din = 16'h0F0F; oe = 1'b1;
        #1;
        expect_bus("R7", model[200]);
        model[5] = 16'h0F0F;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
        #1;
        expect_bus("R7", 16'hFFFF);
        @(negedge clk);
        cs = 1'b1; oe = 1'b1;
        #1;
        expect_bus("R7", model[200]);

        // R8: cs high with oe low releases the bus
        oe = 1'b0;
        #1;
        expect_bus("R8", 16'hFFFF);
        oe = 1'b1;
        rd(5, "R1");
        idle_check();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule